// File: doc/BRIEF.md
# Hardware Semaphore Lock Bank

This block holds a bank of one-bit mutual-exclusion flags that several bus masters share through a simple register port. A master takes a lock with a single read of that lock's word. The read returns the state the lock had just before, and it leaves the lock taken. Software therefore owns the lock when the read returns 0. It gives the lock back by writing 0 to the same word. A requester that reads 1 waits a little longer than half the expected hold time before it retries. The retry wait is a software matter and the block has no logic for it.

Each master has its own port, and all ports act on the bank in the same clock cycle. When requests from several ports hit the same lock in one cycle, they take effect in port order, with port 0 first. This order decides who wins a race between two reads. A read-only status word tells software how many locks the bank holds, so one driver can serve banks of any legal size.

Top module: `semaphore_bank`

## Requirements
- R1: After reset every lock is free, and `rdata` and `ready` are all zero until the first request.
- R2: A read of a free lock's word returns 32'h0000_0000 and leaves that lock taken.
- R3: A read of a taken lock's word returns 32'h0000_0001 and the lock stays taken.
- R4: A write of 32'h0 to a lock's word frees it. A write of any nonzero value to a lock's word leaves its state unchanged.
- R5: Lock i is at byte address 12'h800 + 4*i, for i from 0 to NUM_LOCKS-1. Address bits [1:0] are ignored.
- R6: A read of byte address 12'h014 returns NUM_LOCKS/32 in bits [31:24] and zero in all other bits. NUM_LOCKS must be 32, 64, 128 or 256. Writes to this address change nothing.
- R7: Any address that is neither the status word nor a lock word reads as zero, and a write to it has no effect. This includes 12'h800 + 4*NUM_LOCKS and 12'h7FC. A cycle with no read returns zero data.
- R8: On a lock read, bits [31:1] of the returned word are zero.
- R9: When two ports read the same free lock in the same cycle, the lower-numbered port gets 0 and the other port gets 1.
- R10: Requests in the same cycle take effect in port order. If port 0 frees a lock and port 1 reads it, port 1 gets 0. If port 0 reads a lock and port 1 frees it, port 0 gets the old state and the lock ends free.
- R11: `ready` and `rdata` respond one cycle after a read or write strobe. A port that asserts both strobes at once performs only the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | NUM_PORTS | Read strobe per port; a read of a lock word is a test-and-set |
| wr_en | input | NUM_PORTS | Write strobe per port |
| addr | input | NUM_PORTS*ADDR_W | Byte address per port; port p uses slice p |
| wdata | input | NUM_PORTS*32 | Write data per port |
| rdata | output | NUM_PORTS*32 | Read data per port, valid one cycle after the read |
| ready | output | NUM_PORTS | Response strobe, one cycle after each request |

## Verification
A lock bit that is wrong inside the block shows up only at the next read of that lock. That read returns the wrong old value, and a second read returns the wrong taken state. For this reason every release and every ignored write is followed by a read back through the bus. Port-ordering faults show up in the same cycle that two ports collide. A lost or doubled grant there appears at once as two zeros or two ones in the responses one cycle later. A decode fault shows up as data in the status word, at the first unmapped word, or at the last lock.

// File: rtl/semaphore_bank.sv
module semaphore_bank #(
  parameter int NUM_LOCKS = 32,
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_PORTS-1:0]    rd_en,
  input  logic [NUM_PORTS-1:0]    wr_en,
  input  logic [NUM_PORTS*ADDR_W-1:0] addr,
  input  logic [NUM_PORTS*32-1:0] wdata,
  output logic [NUM_PORTS*32-1:0] rdata,
  output logic [NUM_PORTS-1:0]    ready
);
  localparam int IDX_W  = $clog2(NUM_LOCKS);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] LOCK_WORD = WORD_W'(32'h800 >> 2);
  localparam logic [WORD_W-1:0] STAT_WORD = WORD_W'(32'h014 >> 2);
  localparam logic [31:0] STATUS_VAL = {8'(NUM_LOCKS / 32), 24'h0};

  logic [NUM_LOCKS-1:0] held, held_nxt;
  logic [NUM_PORTS-1:0] hit_lock, hit_stat, zero_wr, got;
  logic [WORD_W-1:0]    word [NUM_PORTS];
  logic [WORD_W-1:0]    offs [NUM_PORTS];
  logic [IDX_W-1:0]     idx  [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    assign word[p]     = addr[p*ADDR_W+2 +: WORD_W];
    assign offs[p]     = word[p] - LOCK_WORD;
    assign idx[p]      = offs[p][IDX_W-1:0];
    assign hit_lock[p] = (word[p] >= LOCK_WORD) && (offs[p] < WORD_W'(NUM_LOCKS));
    assign hit_stat[p] = (word[p] == STAT_WORD);
    assign zero_wr[p]  = (wdata[p*32 +: 32] == 32'h0);
  end

  always_comb begin
    held_nxt = held;
    got      = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rd_en[p] && hit_lock[p]) begin
        got[p]             = held_nxt[idx[p]];
        held_nxt[idx[p]]   = 1'b1;
      end else if (!rd_en[p] && wr_en[p] && hit_lock[p] && zero_wr[p]) begin
        held_nxt[idx[p]]   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= '0;
      ready <= '0;
      rdata <= '0;
    end else begin
      held  <= held_nxt;
      ready <= rd_en | wr_en;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (!rd_en[p])        rdata[p*32 +: 32] <= 32'h0;
        else if (hit_lock[p]) rdata[p*32 +: 32] <= {31'h0, got[p]};
        else if (hit_stat[p]) rdata[p*32 +: 32] <= STATUS_VAL;
        else                  rdata[p*32 +: 32] <= 32'h0;
      end
    end
  end
endmodule

// File: rtl/semaphore_bank_chk.sv
module semaphore_bank_chk #(
  parameter int NUM_LOCKS = 32,
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 12
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_PORTS-1:0]        rd_en,
  input logic [NUM_PORTS-1:0]        wr_en,
  input logic [NUM_PORTS*ADDR_W-1:0] addr,
  input logic [NUM_PORTS*32-1:0]     rdata,
  input logic [NUM_PORTS-1:0]        ready
);
  localparam int WA = ADDR_W - 2;
  logic armed;
  logic [NUM_PORTS-1:0] is_lock, is_stat;

  always_ff @(posedge clk) armed <= !rst;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    logic [WA-1:0] w;
    assign w = addr[p*ADDR_W+2 +: WA];
    assign is_lock[p] = (w >= WA'(32'h200)) && (w < WA'(32'h200 + NUM_LOCKS));
    assign is_stat[p] = (w == WA'(32'h5));

    assert_ready_R11: assert property (@(posedge clk) disable iff (rst)
      armed |-> (ready[p] == $past(rd_en[p] | wr_en[p])));
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (armed && !$past(rd_en[p])) |-> (rdata[p*32 +: 32] == 32'h0));
    assert_unmapped_R7: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(rd_en[p] && !is_lock[p] && !is_stat[p])) |-> (rdata[p*32 +: 32] == 32'h0));
    assert_status_R6: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(rd_en[p] && is_stat[p])) |->
        (rdata[p*32 +: 32] == {8'(NUM_LOCKS / 32), 24'h0}));
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(rd_en[p] && is_lock[p])) |-> (rdata[p*32+1 +: 31] == 31'h0));
  end

  if (NUM_PORTS > 1) begin : g_race
    assert_one_winner_R9: assert property (@(posedge clk) disable iff (rst)
      (armed && $past(rd_en[0] && rd_en[1] && is_lock[0] &&
                      addr[ADDR_W+2 +: WA] == addr[2 +: WA])) |->
        (rdata[0] || rdata[32]));
  end
endmodule

bind semaphore_bank semaphore_bank_chk #(
  .NUM_LOCKS(NUM_LOCKS), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .rdata(rdata), .ready(ready)
);

// File: tb/semaphore_bank_tb_top.sv
module semaphore_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  rd_en = '0, wr_en = '0;
  logic [23:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic [1:0]  ready;
  logic [31:0] q0, q1;
  logic [1:0]  rdy;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  semaphore_bank #(.NUM_LOCKS(32), .NUM_PORTS(2), .ADDR_W(12)) dut_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready));

  always #5 clk = ~clk;

  function automatic logic [11:0] lk(input int i);
    return 12'(32'h800 + 4 * i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r0, input logic w0, input logic [11:0] a0, input logic [31:0] d0,
                      input logic r1, input logic w1, input logic [11:0] a1, input logic [31:0] d1);
    @(negedge clk);
    rd_en = {r1, r0}; wr_en = {w1, w0};
    addr = {a1, a0};  wdata = {d1, d0};
    @(posedge clk); #1;
    q0 = rdata[31:0]; q1 = rdata[63:32]; rdy = ready;
    @(negedge clk);
    rd_en = '0; wr_en = '0;
  endtask

  task automatic rd(input logic [11:0] a);
    step(1, 0, a, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(0, 1, a, d, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    chk("R1 rdata in reset", rdata[31:0] | rdata[63:32], 32'h0);
    chk("R1 ready in reset", {30'h0, ready}, 32'h0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata idle after reset", rdata[31:0] | rdata[63:32], 32'h0);
    for (int i = 0; i < 32; i++) begin
      rd(lk(i));
      chk($sformatf("R1 lock %0d free after reset", i), q0, 32'h0);
    end
    for (int i = 0; i < 32; i++) wr(lk(i), 0);
  endtask

  task automatic t_take;
    rd(lk(5)); chk("R2 free read", q0, 32'h0);
    rd(lk(5)); chk("R3 taken read", q0, 32'h1);
    rd(lk(5)); chk("R3 still taken", q0, 32'h1);
    wr(lk(5), 32'h8000_0000);
    rd(lk(5)); chk("R4 nonzero write ignored", q0, 32'h1);
    wr(lk(5), 0);
    rd(lk(5)); chk("R4 zero write frees", q0, 32'h0);
    rd(lk(6)); chk("R4 neighbour untouched", q0, 32'h0);
    wr(lk(5), 0); wr(lk(6), 0);
  endtask

  task automatic t_map;
    rd(lk(31) | 12'h2); chk("R5 last lock, low bits ignored", q0, 32'h0);
    rd(lk(31));         chk("R5 last lock taken", q0, 32'h1);
    rd(lk(30));         chk("R5 lock 30 separate", q0, 32'h0);
    wr(lk(31) | 12'h3, 0);
    rd(lk(31));         chk("R5 release with low bits set", q0, 32'h0);
    wr(lk(31), 0); wr(lk(30), 0);
    rd(12'h880);        chk("R7 past last lock", q0, 32'h0);
    rd(12'h880);        chk("R7 past last lock no set", q0, 32'h0);
    rd(12'h7FC);        chk("R7 below lock base", q0, 32'h0);
    rd(12'h010);        chk("R7 next to status", q0, 32'h0);
    wr(12'h880, 32'h1);
    rd(12'h880);        chk("R7 write unmapped no effect", q0, 32'h0);
  endtask

  task automatic t_status;
    rd(12'h014); chk("R6 status value", q0, 32'h0100_0000);
    wr(12'h014, 32'hFFFF_FFFF);
    rd(12'h017); chk("R6 status after write", q0, 32'h0100_0000);
  endtask

  task automatic t_upper;
    rd(lk(3));
    rd(lk(3)); chk("R8 upper bits zero", q0, 32'h0000_0001);
    wr(lk(3), 0);
  endtask

  task automatic t_race;
    step(1, 0, lk(7), 0, 1, 0, lk(7), 0);
    chk("R9 port0 wins", q0, 32'h0);
    chk("R9 port1 loses", q1, 32'h1);
    step(1, 0, lk(7), 0, 1, 0, lk(9), 0);
    chk("R9 taken lock on port0", q0, 32'h1);
    chk("R9 other lock on port1", q1, 32'h0);
    wr(lk(7), 0); wr(lk(9), 0);
  endtask

  task automatic t_order;
    rd(lk(8));
    step(0, 1, lk(8), 0, 1, 0, lk(8), 0);
    chk("R10 port1 read after port0 free", q1, 32'h0);
    step(1, 0, lk(8), 0, 0, 1, lk(8), 0);
    chk("R10 port0 read sees taken", q0, 32'h1);
    rd(lk(8)); chk("R10 lock freed by port1", q0, 32'h0);
    wr(lk(8), 0);
  endtask

  task automatic t_resp;
    step(1, 1, lk(10), 0, 0, 0, 0, 0);
    chk("R11 ready port0", {31'h0, rdy[0]}, 32'h1);
    chk("R11 idle port1 not ready", {31'h0, rdy[1]}, 32'h0);
    chk("R11 read wins over write", q0, 32'h0);
    rd(lk(10)); chk("R11 lock stayed taken", q0, 32'h1);
    step(0, 0, 0, 0, 0, 1, lk(10), 0);
    chk("R11 ready on write port1", {30'h0, rdy}, 32'h2);
    chk("R11 write returns zero data", q1, 32'h0);
    rd(lk(10)); chk("R11 port1 write freed", q0, 32'h0);
    wr(lk(10), 0);
    @(posedge clk); #1;
    chk("R11 ready drops when idle", {30'h0, ready}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_take();
    t_map();
    t_status();
    t_upper();
    t_race();
    t_order();
    t_resp();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule